// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor's load/store stage and a data memory that is one 32-bit word wide. For each request it forms a word-aligned memory address. On a store it routes the byte, halfword or word onto the correct byte lanes and raises the matching byte enables. On a load it takes the word that the memory returns one cycle later, picks out the addressed bytes and extends them to 32 bits, either with zeros or with the sign bit. Two configuration inputs are sampled with each request. `cfg_big_endian` selects the byte order, and software is expected to drive it from a control register. `cfg_align_check` selects how misaligned addresses are handled.

When alignment checking is off, the unit clears the low address bits that do not fit the access size. A misaligned word load then returns the aligned word rotated so that the addressed byte comes first. When checking is on, a misaligned halfword or word request is not sent to memory, and an abort pulse answers it instead. The unit never splits one access into two memory transfers.

A small state machine tracks the response slot. It has three states. `ST_IDLE` means no response is due. `ST_LOAD_RESP` means load data returns in this cycle. `ST_FAULT` means an abort is reported in this cycle. Each cycle the state is chosen again from the request presented in that cycle: a faulting request leads to `ST_FAULT`, an accepted read leads to `ST_LOAD_RESP`, and a write or no request leads to `ST_IDLE`. These transitions apply from every state, so requests can follow one another on back-to-back cycles.

Top module: `lsu_lane_unit`

## Requirements
- R1: The size code on `req_size` is 00 for byte, 01 for halfword and 10 for word; 11 behaves as word. A byte store enables exactly one lane. That lane is the address offset `a[1:0]` in little-endian mode and `a[1:0]` XOR 3 in big-endian mode, and the lane carries `req_wdata[7:0]`.
- R2: A halfword store first clears address bit 0 to give offset e. In little-endian mode it puts `req_wdata[7:0]` on lane e and `req_wdata[15:8]` on lane e+1. In big-endian mode the byte at address e is the high byte and sits on lane e XOR 3, and the byte at address e+1 is the low byte and sits on lane (e+1) XOR 3.
- R3: A word store enables all four lanes. Lane k carries bits [8k+7:8k] of `req_wdata` in both byte orders, and the data is never rotated, whatever the address offset.
- R4: An accepted request raises `mem_req` in the same cycle. `mem_we` copies `req_write`, and `mem_addr` is the request address with bits [1:0] cleared.
- R5: A read accepted in cycle n gives a single-cycle `ld_valid` pulse in cycle n+1, and `ld_data` is formed from `mem_rdata` of that cycle.
- R6: Byte and halfword loads return the bytes that R1/R2 would write for the same address and byte order. The result is zero-extended when `req_signed` is 0 and sign-extended when it is 1.
- R7: With checking off, a word load at offset o ≠ 0 rotates the aligned word. In little-endian mode it rotates right by 8·o bits. In big-endian mode it rotates left by 8·o bits. In both cases the byte at the addressed location ends up as the first byte of the result in that byte order.
- R8: With checking on, a halfword at an odd address, or a word (or code 11) at a nonzero offset, raises no `mem_req`. It is answered by a single-cycle `ld_abort` in the next cycle, with no `ld_valid`. Byte accesses never abort.
- R9: While and after reset, with no request, `mem_req`, `ld_valid` and `ld_abort` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-justified |
| cfg_big_endian | input | 1 | Byte order select |
| cfg_align_check | input | 1 | Abort on misaligned access |
| mem_req | output | 1 | Memory transfer strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Memory read word, one cycle after read |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 32 | Extended load result |
| ld_abort | output | 1 | Alignment abort strobe |

## Verification
The bound assertions check, on every cycle, the properties that do not depend on data values. A read is always answered one cycle later. A checked misaligned request never reaches memory and is always followed by an abort. Store enables always cover exactly as many lanes as the access size. The memory address is always word-aligned. An unsigned byte result never has high bits set. The bench scenarios are needed for the lane arithmetic itself: the XOR lane mapping in big-endian mode, the byte order inside a halfword, the direction of the rotation for a misaligned word, and the extension of the sign bit. A reference memory and a behavioural byte-address model in the bench expose these values.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_LOAD_RESP = 2'b01,
        ST_FAULT     = 2'b10
    } lsu_state_e;

    typedef struct packed {
        logic [LANE_W-1:0] off;
        acc_size_e         size;
        logic              sgn;
        logic              big;
        logic              chk;
    } load_ctx_t;
endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
    import lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] off,
    input  logic              big,
    output logic [LANE_W-1:0] lane,
    output logic              misaligned
);
    logic [LANE_W-1:0] eff;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                misaligned = 1'b0;
                eff        = off;
                lane       = big ? (eff ^ 2'd3) : eff;
            end
            SZ_HALF: begin
                misaligned = off[0];
                eff        = {off[1], 1'b0};
                lane       = big ? (eff ^ 2'd2) : eff;
            end
            default: begin
                misaligned = (off != '0);
                eff        = '0;
                lane       = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
    import lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_BYTES-1:0] be,
    output logic [WORD_W-1:0] data
);
    logic [LANE_W+2:0] shamt;

    assign shamt = {lane, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be   = 4'b0001 << lane;
                data = {24'b0, wdata[7:0]} << shamt;
            end
            SZ_HALF: begin
                be   = 4'b0011 << lane;
                data = {16'b0, wdata[15:0]} << shamt;
            end
            default: begin
                be   = '1;
                data = wdata;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
    import lsu_pkg::*;
(
    input  load_ctx_t         ctx,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result
);
    logic [LANE_W+2:0]   shamt;
    logic [LANE_W+2:0]   rot;
    logic [WORD_W-1:0]   lane_shifted;
    logic [2*WORD_W-1:0] doubled;
    logic [2*WORD_W-1:0] ror_full;
    logic [2*WORD_W-1:0] rol_full;
    logic [WORD_W-1:0]   word_val;

    assign shamt        = {lane, 3'b000};
    assign rot          = ctx.chk ? '0 : {ctx.off, 3'b000};
    assign lane_shifted = rdata >> shamt;
    assign doubled      = {rdata, rdata};
    assign ror_full     = doubled >> rot;
    assign rol_full     = doubled << rot;
    assign word_val     = ctx.big ? rol_full[2*WORD_W-1:WORD_W] : ror_full[WORD_W-1:0];

    always_comb begin
        unique case (ctx.size)
            SZ_BYTE: result = {{24{ctx.sgn & lane_shifted[7]}},  lane_shifted[7:0]};
            SZ_HALF: result = {{16{ctx.sgn & lane_shifted[15]}}, lane_shifted[15:0]};
            default: result = word_val;
        endcase
    end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic fault,
    output logic mem_go,
    output logic ctx_capture,
    output logic resp_valid,
    output logic resp_abort
);
    lsu_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_LOAD_RESP, ST_FAULT: begin
                if (req_valid && fault)           state_nx = ST_FAULT;
                else if (req_valid && !req_write) state_nx = ST_LOAD_RESP;
                else                              state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_go      = req_valid && !fault;
        ctx_capture = req_valid && !fault && !req_write;
        resp_valid  = (state == ST_LOAD_RESP);
        resp_abort  = (state == ST_FAULT);
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              cfg_big_endian,
    input  logic              cfg_align_check,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              ld_abort
);
    acc_size_e         size_in;
    logic [LANE_W-1:0] req_lane;
    logic              req_misaligned;
    logic              fault;
    logic              capture;
    load_ctx_t         ctx_q;
    load_ctx_t         ctx_d;
    logic [LANE_W-1:0] ld_lane;
    logic              ld_mis_unused;

    assign size_in = acc_size_e'(req_size);

    lsu_lane_map u_req_map (
        .size       (size_in),
        .off        (req_addr[LANE_W-1:0]),
        .big        (cfg_big_endian),
        .lane       (req_lane),
        .misaligned (req_misaligned)
    );

    assign fault = cfg_align_check && req_misaligned;

    lsu_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .fault       (fault),
        .mem_go      (mem_req),
        .ctx_capture (capture),
        .resp_valid  (ld_valid),
        .resp_abort  (ld_abort)
    );

    assign mem_we   = req_write;
    assign mem_addr = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    lsu_store_path u_store (
        .size  (size_in),
        .lane  (req_lane),
        .wdata (req_wdata),
        .be    (mem_be),
        .data  (mem_wdata)
    );

    always_comb begin
        ctx_d.off  = req_addr[LANE_W-1:0];
        ctx_d.size = size_in;
        ctx_d.sgn  = req_signed;
        ctx_d.big  = cfg_big_endian;
        ctx_d.chk  = cfg_align_check;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ctx_q <= '0;
        else if (capture) ctx_q <= ctx_d;
    end

    lsu_lane_map u_ld_map (
        .size       (ctx_q.size),
        .off        (ctx_q.off),
        .big        (ctx_q.big),
        .lane       (ld_lane),
        .misaligned (ld_mis_unused)
    );

    lsu_load_path u_load (
        .ctx    (ctx_q),
        .lane   (ld_lane),
        .rdata  (mem_rdata),
        .result (ld_data)
    );
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              req_signed,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cfg_align_check,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              ld_valid,
    input logic [31:0]       ld_data,
    input logic              ld_abort
);
    logic odd_req;
    assign odd_req = req_valid && cfg_align_check &&
                     ((req_size == 2'b01 && req_addr[0]) ||
                      (req_size[1] && req_addr[1:0] != 2'b00));

    AST_STORE_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && req_size == 2'b00 |-> $countones(mem_be) == 1); // R1
    AST_STORE_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && req_size == 2'b01 |-> $countones(mem_be) == 2); // R2
    AST_STORE_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && req_size[1] |-> mem_be == 4'hF); // R3
    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2] && mem_we == req_write); // R4
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |=> ld_valid); // R5
    AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_req && !mem_we)); // R5
    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && $past(req_size == 2'b00 && !req_signed) |-> ld_data[31:8] == 24'h0); // R6
    AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        odd_req |-> !mem_req); // R8
    AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        odd_req |=> ld_abort && !ld_valid); // R8
    AST_ABORT_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_abort |-> $past(odd_req)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !mem_req); // R9
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lsu_lane_unit.sv
`timescale 1ns/1ps
module sim_lsu_lane_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          cfg_big_endian = 1'b0, cfg_align_check = 1'b0;
    logic          mem_req, mem_we, ld_valid, ld_abort;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata, ld_data;
    logic [31:0]   mem_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] phys [16];
    logic [31:0] refm [16];
    logic        pend_ld = 1'b0, pend_ab = 1'b0;
    logic [31:0] pend_data = '0;
    string       pend_tag = "R6";

    always #10 clk = ~clk;

    lsu_lane_unit #(.ADDR_W(AW)) u0 (.*);

    function automatic logic [31:0] pat(int i);
        return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A3C_81F6;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) phys[i] <= pat(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) phys[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= phys[mem_addr[5:2]];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(logic [31:0] w, int a, logic big);
        return big ? w[8*(3-a) +: 8] : w[8*a +: 8];
    endfunction

    function automatic logic [31:0] exp_load(logic [31:0] w, int off, int sz, logic sg, logic big, logic ck);
        logic [31:0] r;
        int e;
        int o;
        r = '0;
        if (sz == 0) begin
            r[7:0] = byte_at(w, off, big);
            if (sg && r[7]) r[31:8] = '1;
        end else if (sz == 1) begin
            e = off & 2;
            r[15:0] = big ? {byte_at(w, e, big), byte_at(w, e+1, big)}
                          : {byte_at(w, e+1, big), byte_at(w, e, big)};
            if (sg && r[15]) r[31:16] = '1;
        end else begin
            o = ck ? 0 : off;
            for (int k = 0; k < 4; k++) begin
                if (big) r[8*(3-k) +: 8] = byte_at(w, (o + k) % 4, big);
                else     r[8*k +: 8]     = byte_at(w, (o + k) % 4, big);
            end
        end
        return r;
    endfunction

    task automatic put_byte(inout logic [3:0] be, inout logic [31:0] wd, input int a, input logic [7:0] v, input logic big);
        int lane;
        lane = big ? 3 - a : a;
        be[lane] = 1'b1;
        wd[8*lane +: 8] = v;
    endtask

    task automatic step(input logic v, input logic we, input int sz, input logic sg,
                        input int a, input logic [31:0] wd, input logic big, input logic ck);
        logic        mis, ereq;
        logic [3:0]  ebe;
        logic [31:0] ewd, mask;
        int          off, idx, e;
        string       stag;
        @(negedge clk);
        chk("R5 ld_valid", {31'b0, ld_valid}, {31'b0, pend_ld});
        chk("R8 ld_abort", {31'b0, ld_abort}, {31'b0, pend_ab});
        if (pend_ld) chk(pend_tag, ld_data, pend_data);
        req_valid = v; req_write = we; req_size = sz[1:0]; req_signed = sg;
        req_addr = AW'(a); req_wdata = wd; cfg_big_endian = big; cfg_align_check = ck;
        #1;
        off  = a % 4;
        idx  = (a / 4) % 16;
        mis  = (sz == 1 && (off % 2) == 1) || (sz >= 2 && off != 0);
        ereq = v && !(ck && mis);
        chk(ck && mis ? "R8 mem_req" : "R4 mem_req", {31'b0, mem_req}, {31'b0, ereq});
        if (ereq) begin
            chk("R4 mem_addr", mem_addr, AW'(a & ~3));
            chk("R4 mem_we", {31'b0, mem_we}, {31'b0, we});
            if (we) begin
                ebe = '0; ewd = '0;
                if (sz == 0) begin
                    put_byte(ebe, ewd, off, wd[7:0], big);
                    stag = "R1";
                end else if (sz == 1) begin
                    e = off & 2;
                    put_byte(ebe, ewd, e,     big ? wd[15:8] : wd[7:0], big);
                    put_byte(ebe, ewd, e + 1, big ? wd[7:0]  : wd[15:8], big);
                    stag = "R2";
                end else begin
                    for (int k = 0; k < 4; k++)
                        put_byte(ebe, ewd, k, big ? wd[8*(3-k) +: 8] : wd[8*k +: 8], big);
                    stag = "R3";
                end
                mask = {{8{ebe[3]}}, {8{ebe[2]}}, {8{ebe[1]}}, {8{ebe[0]}}};
                chk({stag, " mem_be"}, {28'b0, mem_be}, {28'b0, ebe});
                chk({stag, " mem_wdata"}, mem_wdata & mask, ewd);
                for (int k = 0; k < 4; k++)
                    if (ebe[k]) refm[idx][8*k +: 8] = ewd[8*k +: 8];
            end
        end
        pend_ld = ereq && !we;
        pend_ab = v && ck && mis;
        if (pend_ld) begin
            pend_data = exp_load(refm[idx], off, sz, sg, big, ck);
            pend_tag  = (sz >= 2 && off != 0) ? "R7 ld_data" : "R6 ld_data";
        end
    endtask

    initial begin
        #5_000_000;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) refm[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R9 ld_valid", {31'b0, ld_valid}, 32'd0);
        chk("R9 ld_abort", {31'b0, ld_abort}, 32'd0);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R9 ld_valid idle", {31'b0, ld_valid}, 32'd0);

        // R6 R7: loads, every size, offset, sign and byte order, checking off
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 3; s++)
                for (int o = 0; o < 4; o++)
                    for (int g = 0; g < 2; g++)
                        step(1, 0, s, g[0], 4 * (s + 4 * g) + o, 0, b[0], 0);

        // R1 R2 R3: stores followed by read-back in both byte orders
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 3; s++)
                for (int o = 0; o < 4; o++) begin
                    step(1, 1, s, 0, 40 + o, 32'hC3A5_9187 + 32'(o * 16 + s), b[0], 0);
                    step(1, 0, 2, 0, 40, 0, b[0], 0);
                    step(1, 0, s, 1, 40 + o, 0, b[0], 0);
                end

        // R8: alignment checking on
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++) begin
                    step(1, 0, s, 0, 20 + o, 0, b[0], 1);
                    step(1, 1, s, 0, 24 + o, 32'h7E11_D00D, b[0], 1);
                end

        // mixed back-to-back traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom;
            step(r[0] | r[1], r[2], r[4:3] == 2'b11 ? 2 : int'(r[4:3]), r[5],
                 int'(r[11:6]), $urandom, r[12], r[13] & r[14]);
        end
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule